// File: doc/BRIEF.md
# Strobed Input Port with Buffer-Full Handshake

This block receives bytes from a parallel peripheral that signals each byte with an active-low strobe. Both the strobe and the data pins come through a two-stage synchroniser. A falling edge on the synchronised strobe copies the synchronised pins into a holding register and marks the buffer full. The sender sees the full flag drop when the host takes the byte, and it can use that drop as its acknowledge.

The byte goes to the host over a valid/ready stream. `out_valid` is the buffer-full flag. It stays high, and `out_data` holds still, until the host accepts the byte with `out_ready`. Back-pressure does not stall the sender. A new strobe that arrives while the byte has not been accepted overwrites the held byte and sets a sticky overrun bit.

An interrupt request is gated by an enable bit, which the host sets or clears with a one-cycle command. The host can also poll the request in a status word instead of wiring it to an interrupt controller.

Top module: `strobed_in_port`

## Requirements
- R1: A falling edge of `strobe_n` captures `pin_data` into `out_data`. The edge must be preceded by at least two clocks high and followed by at least two clocks low. The byte is visible after the third rising clock edge that follows the change on the pins.
- R2: `out_valid` rises with a capture and stays high, with `out_data` unchanged, until it is accepted.
- R3: A cycle with `out_valid` and `out_ready` both high is an accept. `out_valid` is low in the next cycle unless a capture lands in the same cycle. `out_ready` while `out_valid` is low has no effect.
- R4: `irq` rises only on a capture edge that arrives while the interrupt enable is set.
- R5: A cycle with `ie_cmd_valid` high loads the enable from `ie_cmd_val`. A clear command forces `irq` low. This takes priority over a capture in the same cycle. After a set command, `irq` stays low until the next capture edge.
- R6: An accept with no capture in the same cycle drops `irq`.
- R7: Reset clears `out_valid`, `irq`, the enable and the overrun bit. Reset leaves `out_data` unchanged.
- R8: A capture while `out_valid` is high and no accept is taking place replaces `out_data` and sets an overrun bit. The bit stays set until reset. A capture in the same cycle as an accept does not set it.
- R9: `status` packs the state: bit 0 is full, bit 1 is irq, bit 2 is the enable, and bit 3 is overrun.
- R10: A strobe that is held low causes exactly one capture. No second capture happens until the strobe has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_n | input | 1 | Asynchronous active-low strobe from the sender |
| pin_data | input | 8 | Asynchronous data pins |
| out_data | output | 8 | Captured byte |
| out_valid | output | 1 | Buffer full, byte waiting |
| out_ready | input | 1 | Host accepts the byte |
| ie_cmd_valid | input | 1 | Enable bit command strobe |
| ie_cmd_val | input | 1 | Value written to the enable bit |
| irq | output | 1 | Interrupt request |
| status | output | 4 | {overrun, enable, irq, full} |

## Verification
A table of bytes is sent through the main capture path. The table mixes alternating bits, all-ones, all-zeros and single-bit patterns, so a dropped or swapped data bit shows up. Each byte is sent with the enable either set or clear, which separates a request raised by an edge from one that ignores the enable. Directed cases then check these corners:
- a strobe held low for many cycles;
- a capture that coincides with an accept, which must not count as an overrun;
- a true overrun;
- clear and set commands around a pending request;
- a reset that must keep the held byte.

// File: rtl/sip_pkg.sv
package sip_pkg;
  localparam int STAT_W    = 4;
  localparam int STAT_FULL = 0;
  localparam int STAT_IRQ  = 1;
  localparam int STAT_IE   = 2;
  localparam int STAT_OVR  = 3;
endpackage

// File: rtl/sip_sync.sv
module sip_sync #(
  parameter int       WIDTH   = 8,
  parameter int       STAGES  = 2,
  parameter bit       RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  localparam logic [WIDTH-1:0] RST_WORD = {WIDTH{RST_VAL}};

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= RST_WORD;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= RST_WORD;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/sip_fall_detect.sv
module sip_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level;
  end

  assign fall = prev_q & ~level;

  // R10: a fall cannot repeat in consecutive cycles
  a_r10_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/sip_capture.sv
module sip_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic [DATA_W-1:0] din,
  input  logic              take,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              overrun
);
  // Holding register: deliberately not reset (R7)
  always_ff @(posedge clk) begin
    if (fall) data <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (fall)      full <= 1'b1;
      else if (take) full <= 1'b0;
      if (fall && full && !take) overrun <= 1'b1;
    end
  end

  a_r2_full_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> full);
  a_r2_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !fall) |=> (data == $past(data)));
  a_r3_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !fall) |=> !full);
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: rtl/sip_irq.sv
module sip_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic take,
  input  logic cmd_valid,
  input  logic cmd_val,
  output logic ie,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie  <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (cmd_valid) ie <= cmd_val;
      if (cmd_valid && !cmd_val) irq <= 1'b0;
      else if (fall && ie)       irq <= 1'b1;
      else if (take)             irq <= 1'b0;
    end
  end

  a_r4_rise_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(fall) && $past(ie)));
  a_r5_clear_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_val) |=> !irq);
  a_r6_accept_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !fall) |=> !irq);
endmodule

// File: rtl/strobed_in_port.sv
module strobed_in_port
  import sip_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic [DATA_W-1:0] pin_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic              ie_cmd_valid,
  input  logic              ie_cmd_val,
  output logic              irq,
  output logic [STAT_W-1:0] status
);
  logic              stb_s;
  logic [DATA_W-1:0] pin_s;
  logic              fall;
  logic              take;
  logic              full;
  logic              overrun;
  logic              ie;

  sip_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .d_async(strobe_n), .d_sync(stb_s));

  sip_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_data), .d_sync(pin_s));

  sip_fall_detect u_fall (
    .clk(clk), .rst_n(rst_n), .level(stb_s), .fall(fall));

  assign take = full & out_ready;

  sip_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .fall(fall), .din(pin_s), .take(take),
    .data(out_data), .full(full), .overrun(overrun));

  sip_irq u_irq (
    .clk(clk), .rst_n(rst_n), .fall(fall), .take(take),
    .cmd_valid(ie_cmd_valid), .cmd_val(ie_cmd_val), .ie(ie), .irq(irq));

  assign out_valid = full;

  always_comb begin
    status            = '0;
    status[STAT_FULL] = full;
    status[STAT_IRQ]  = irq;
    status[STAT_IE]   = ie;
    status[STAT_OVR]  = overrun;
  end

  // R5: a request never stands while interrupts are disabled
  a_r5_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie);
endmodule

// File: tb/strobed_in_port_tb.sv
module strobed_in_port_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       strobe_n;
  logic [7:0] pin_data;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready;
  logic       ie_cmd_valid;
  logic       ie_cmd_val;
  logic       irq;
  logic [3:0] status;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  strobed_in_port u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .pin_data(pin_data),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .ie_cmd_valid(ie_cmd_valid), .ie_cmd_val(ie_cmd_val),
    .irq(irq), .status(status));

  // {ie, byte}
  localparam logic [8:0] VEC [8] = '{
    {1'b1, 8'hA5}, {1'b0, 8'h5A}, {1'b1, 8'hFF}, {1'b0, 8'h00},
    {1'b1, 8'h01}, {1'b1, 8'h80}, {1'b0, 8'h3C}, {1'b1, 8'hC3}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_ie(input logic v);
    @(negedge clk); ie_cmd_valid = 1'b1; ie_cmd_val = v;
    @(negedge clk); ie_cmd_valid = 1'b0;
  endtask

  task automatic strobe_fall(input logic [7:0] d);
    @(negedge clk); pin_data = d; strobe_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe_rise();
    strobe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic accept();
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strobe_n = 1'b1; pin_data = 8'h00;
    out_ready = 1'b0; ie_cmd_valid = 1'b0; ie_cmd_val = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset status", status, 4'h0);
    check("R7 reset valid", out_valid, 1'b0);

    // R3: ready with no byte waiting has no effect
    accept();
    check("R3 idle ready", out_valid, 1'b0);

    // Table walk: R1 R2 R4 R6 R9
    for (int i = 0; i < 8; i++) begin
      set_ie(VEC[i][8]);
      strobe_fall(VEC[i][7:0]);
      check("R1 data", out_data, VEC[i][7:0]);
      check("R2 valid", out_valid, 1'b1);
      check("R4 irq", irq, VEC[i][8]);
      check("R9 status", status, {1'b0, VEC[i][8], VEC[i][8], 1'b1});
      strobe_rise();
      check("R2 held", out_data, VEC[i][7:0]);
      accept();
      check("R3 accept", out_valid, 1'b0);
      check("R6 irq drop", irq, 1'b0);
    end

    // R5: clearing the enable forces the request low; setting it keeps it low
    set_ie(1'b1);
    strobe_fall(8'h66); strobe_rise();
    check("R4 irq pending", irq, 1'b1);
    set_ie(1'b0);
    check("R5 clear forces low", irq, 1'b0);
    set_ie(1'b1);
    check("R5 set keeps low", irq, 1'b0);
    check("R5 valid untouched", out_valid, 1'b1);
    accept();
    strobe_fall(8'h77); strobe_rise();
    check("R5 next edge raises", irq, 1'b1);
    accept();

    // R10: held strobe gives one capture
    strobe_fall(8'h12);
    check("R10 first capture", out_valid, 1'b1);
    accept();
    pin_data = 8'h34;
    repeat (10) @(negedge clk);
    check("R10 no second capture", out_valid, 1'b0);
    check("R10 data kept", out_data, 8'h12);
    strobe_rise();

    // R8: capture coinciding with accept is not an overrun
    strobe_fall(8'h21); strobe_rise();
    @(negedge clk); pin_data = 8'h43; strobe_n = 1'b0;
    @(negedge clk);
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    check("R8 same-cycle valid", out_valid, 1'b1);
    check("R8 same-cycle data", out_data, 8'h43);
    check("R8 no overrun", status[3], 1'b0);
    strobe_rise();

    // R8: true overrun overwrites and sticks
    strobe_fall(8'h99); strobe_rise();
    check("R8 overwrite", out_data, 8'h99);
    check("R8 overrun set", status[3], 1'b1);
    accept();
    check("R8 overrun sticky", status[3], 1'b1);

    // R7: reset keeps the held byte
    strobe_fall(8'hB7); strobe_rise();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R7 status cleared", status, 4'h0);
    check("R7 data kept", out_data, 8'hB7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule